// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block holds the interrupt and status registers of an SD/MMC host controller. The command, data and DMA engines report events as one-cycle pulses. The block latches each pulse into one of two words. The event word holds completion and readiness events. The fault word holds protocol and transfer errors. Software clears a latched bit by writing a one to it. Bit 15 of the event word is not stored: it is a summary that reads as the OR of every latched fault bit. A single level-sensitive interrupt line comes from the event word and an enable register. Each word also has its own register that stops chosen events from latching.

Software reaches the registers through a simple bus. The bus has a word address, a write strobe and write data. Only the low 16 bits of the write data are used, and reads return 16 bits combinationally. The block also holds a self-clearing soft-reset bit, which is driven out to the engines as `soft_rst_o`. A read-only word mirrors six live status lines from the engines.

Top module: `sdis_irq_status`

## Requirements
- R1: All registers are 16 bits wide. A write uses only `wdata_i[15:0]`. Bits that have no function read 0. The word addresses are: 0 event status, 1 fault status, 2 event block, 3 fault block, 4 event enable, 5 fault enable, 6 soft reset, 7 live status.
- R2: An event pulse on `evt_i` latches the bit at the same position in the event word. The live bits are 0 command done, 1 data done, 2 block gap, 3 DMA done, 4 write ready, 5 read ready, 8 card interrupt, 10 eight-word read ready and 11 eight-word write ready. A pulse on any other bit leaves the word at 0.
- R3: A pulse on `flt_i` latches the fault word. The live bits are 0 to 6 and 8 to 14: command timeout, CRC, end bit and index; data timeout, CRC and end bit; auto stop-command error; command start; transfer size; response T bit; CRC end bit, CRC start bit and CRC status. Bits 7 and 15 stay 0.
- R4: Writing a 1 to a bit of address 0 or 1 clears that bit. Writing 0xFFFF clears every bit. Writing 0 changes nothing.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: Bit 15 of the event word reads 1 exactly when any fault bit is latched. Writing a 1 to it leaves the fault word unchanged.
- R7: A 1 in the event block register (address 2, writable on the live event bits) stops the matching event from latching.
- R8: Only bit 4 (data timeout) of the fault block register is writable. While it is 1, a data-timeout pulse does not latch. Every other bit of that register reads 0.
- R9: `irq_o` is 1 when some event bit is set together with its enable bit (address 4, writable on the live event bits and bit 15). It is also 1 when enable bit 15 is set and some fault bit is set together with its fault enable bit (address 5). Writing 0 to the enables drops `irq_o` and leaves both status words unchanged.
- R10: Writing 1 to bit 8 of address 6 starts a soft reset. Bit 8 reads 1 and `soft_rst_o` is 1 for 4 cycles, and then both return to 0. During the reset all status, block and enable registers go to 0, and event pulses and register writes are ignored.
- R11: Address 7 mirrors the live inputs: bit 0 command inhibit, bit 1 card busy, bit 8 transmit active, bit 9 receive active, bit 12 FIFO full, bit 13 FIFO empty.
- R12: After `rst_ni` is released, every stored register reads 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data (low 16 bits used) |
| rdata_o | output | 16 | Read data for `addr_i` |
| evt_i | input | 16 | Event pulses, one cycle each |
| flt_i | input | 16 | Fault pulses, one cycle each |
| cmd_inhibit_i | input | 1 | Live: command line in use |
| card_busy_i | input | 1 | Live: card signals busy |
| tx_active_i | input | 1 | Live: transmit in progress |
| rx_active_i | input | 1 | Live: receive in progress |
| fifo_full_i | input | 1 | Live: FIFO full |
| fifo_empty_i | input | 1 | Live: FIFO empty |
| irq_o | output | 1 | Interrupt request, level |
| soft_rst_o | output | 1 | Soft reset in progress |

## Verification
Single-bit pulses are swept over all 16 positions of both words. This separates the live bits from the unused ones and confirms the bit layout. An all-ones pulse with one bit blocked at a time shows that each block bit acts only on its own position. Each enable bit is tried alone against its own status bit and against a neighbouring one, which tells a correct enable match from a stuck or shifted one. Clears that coincide with events, all 64 patterns of the live-status inputs, and a reset sequence sampled cycle by cycle cover the orderings and timing.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
   localparam int REG_W        = 16;
   localparam int SUMMARY_BIT  = 15;
   localparam int RESET_BIT    = 8;
   // live bit positions of each word
   localparam logic [REG_W-1:0] EVT_LIVE   = 16'h0D3F;
   localparam logic [REG_W-1:0] FLT_LIVE   = 16'h7F7F;
   localparam logic [REG_W-1:0] FLT_BLK_WR = 16'h0010;
   localparam logic [REG_W-1:0] EVT_EN_WR  = EVT_LIVE | (16'h1 << SUMMARY_BIT);
   // live status positions
   localparam int HS_INHIBIT = 0;
   localparam int HS_BUSY    = 1;
   localparam int HS_TX      = 8;
   localparam int HS_RX      = 9;
   localparam int HS_FULL    = 12;
   localparam int HS_EMPTY   = 13;

   typedef enum logic [2:0] {
      RA_EVT_STAT = 3'd0,
      RA_FLT_STAT = 3'd1,
      RA_EVT_BLK  = 3'd2,
      RA_FLT_BLK  = 3'd3,
      RA_EVT_EN   = 3'd4,
      RA_FLT_EN   = 3'd5,
      RA_SRST     = 3'd6,
      RA_LIVE     = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/sdis_w1c_bank.sv
module sdis_w1c_bank #(
   parameter int            W     = 16,
   parameter logic [W-1:0]  LIVE  = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         srst_i,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] blk_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_data_i,
   output logic [W-1:0] stat_o
);
   if (W < 1) begin : g_bad_w
      $error("sdis_w1c_bank: W must be positive");
   end

   logic unused_in;
   assign unused_in = ^{evt_i & ~LIVE, blk_i & ~LIVE, clr_data_i & ~LIVE};

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      q <= 1'b0;
            else if (srst_i)  q <= 1'b0;
            else              q <= (q & ~(clr_we_i & clr_data_i[i]))
                                   | (evt_i[i] & ~blk_i[i]);
         end
         assign stat_o[i] = q;

         // R5: an unblocked event always lands, even with a clear
         a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!srst_i && evt_i[i] && !blk_i[i]) |=> stat_o[i]);
         // R4: a clear without a competing event empties the bit
         a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!srst_i && clr_we_i && clr_data_i[i] && !evt_i[i]) |=> !stat_o[i]);
         // R7: a blocked event with no prior state leaves the bit clear
         a_r7_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!srst_i && !stat_o[i] && blk_i[i]) |=> !stat_o[i]);
         // R10: soft reset empties the bit
         a_r10_bank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            srst_i |=> !stat_o[i]);
      end else begin : g_tie
         assign stat_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sdis_cfg_reg.sv
module sdis_cfg_reg #(
   parameter int            W     = 16,
   parameter logic [W-1:0]  WMASK = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         srst_i,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("sdis_cfg_reg: W must be positive");
   end

   logic unused_wd;
   assign unused_wd = ^(wdata_i & ~WMASK);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (WMASK[i]) begin : g_rw
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     q <= 1'b0;
            else if (srst_i) q <= 1'b0;
            else if (we_i)   q <= wdata_i[i];
         end
         assign q_o[i] = q;
      end else begin : g_ro
         assign q_o[i] = 1'b0;
      end
   end

   // R10: soft reset zeroes the register
   a_r10_cfg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (q_o == '0));
   // R1: without a write the register holds
   a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && !we_i) |=> $stable(q_o));
endmodule

// File: rtl/sdis_softreset.sv
module sdis_softreset #(
   parameter int CYCLES = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("sdis_softreset: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
         end
      end else if (cnt_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;

   // R10: a start from idle raises busy next cycle
   a_r10_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o);
   // R10: the last counted cycle ends the reset
   a_r10_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cnt_q == '0) |=> !busy_o);
endmodule

// File: rtl/sdis_irq_status.sv
module sdis_irq_status
   import sdis_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 32,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   input  logic [REG_W-1:0]  evt_i,
   input  logic [REG_W-1:0]  flt_i,
   input  logic              cmd_inhibit_i,
   input  logic              card_busy_i,
   input  logic              tx_active_i,
   input  logic              rx_active_i,
   input  logic              fifo_full_i,
   input  logic              fifo_empty_i,
   output logic              irq_o,
   output logic              soft_rst_o
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("sdis_irq_status: ADDR_W must be at least 3");
   end
   if (DATA_W < REG_W) begin : g_bad_data
      $error("sdis_irq_status: DATA_W must cover the register width");
   end

   logic [REG_W-1:0] wd;
   logic             unused_hi;
   assign wd        = wdata_i[REG_W-1:0];
   assign unused_hi = ^wdata_i;

   logic busy;
   logic wr_ok;
   assign wr_ok = wr_en_i && !busy;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
      return a == ADDR_W'(r);
   endfunction

   logic we_evt_stat, we_flt_stat, we_evt_blk, we_flt_blk, we_evt_en, we_flt_en, srst_start;
   always_comb begin
      we_evt_stat = wr_ok && hit(addr_i, RA_EVT_STAT);
      we_flt_stat = wr_ok && hit(addr_i, RA_FLT_STAT);
      we_evt_blk  = wr_ok && hit(addr_i, RA_EVT_BLK);
      we_flt_blk  = wr_ok && hit(addr_i, RA_FLT_BLK);
      we_evt_en   = wr_ok && hit(addr_i, RA_EVT_EN);
      we_flt_en   = wr_ok && hit(addr_i, RA_FLT_EN);
      srst_start  = wr_ok && hit(addr_i, RA_SRST) && wd[RESET_BIT];
   end

   sdis_softreset #(.CYCLES(RST_CYCLES)) u_srst (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (srst_start),
      .busy_o  (busy)
   );

   logic [REG_W-1:0] evt_blk_q, flt_blk_q, evt_en_q, flt_en_q;
   logic [REG_W-1:0] evt_stat_q, flt_stat_q;

   sdis_cfg_reg #(.W(REG_W), .WMASK(EVT_LIVE)) u_evt_blk (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .we_i(we_evt_blk), .wdata_i(wd), .q_o(evt_blk_q));
   sdis_cfg_reg #(.W(REG_W), .WMASK(FLT_BLK_WR)) u_flt_blk (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .we_i(we_flt_blk), .wdata_i(wd), .q_o(flt_blk_q));
   sdis_cfg_reg #(.W(REG_W), .WMASK(EVT_EN_WR)) u_evt_en (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .we_i(we_evt_en), .wdata_i(wd), .q_o(evt_en_q));
   sdis_cfg_reg #(.W(REG_W), .WMASK(FLT_LIVE)) u_flt_en (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .we_i(we_flt_en), .wdata_i(wd), .q_o(flt_en_q));

   sdis_w1c_bank #(.W(REG_W), .LIVE(EVT_LIVE)) u_evt_stat (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .evt_i(evt_i), .blk_i(evt_blk_q),
      .clr_we_i(we_evt_stat), .clr_data_i(wd), .stat_o(evt_stat_q));
   sdis_w1c_bank #(.W(REG_W), .LIVE(FLT_LIVE)) u_flt_stat (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(busy),
      .evt_i(flt_i), .blk_i(flt_blk_q),
      .clr_we_i(we_flt_stat), .clr_data_i(wd), .stat_o(flt_stat_q));

   logic             any_flt;
   logic [REG_W-1:0] evt_view;
   logic [REG_W-1:0] live_word;
   always_comb begin
      any_flt               = |flt_stat_q;
      evt_view              = evt_stat_q;
      evt_view[SUMMARY_BIT] = any_flt;
      live_word             = '0;
      live_word[HS_INHIBIT] = cmd_inhibit_i;
      live_word[HS_BUSY]    = card_busy_i;
      live_word[HS_TX]      = tx_active_i;
      live_word[HS_RX]      = rx_active_i;
      live_word[HS_FULL]    = fifo_full_i;
      live_word[HS_EMPTY]   = fifo_empty_i;
   end

   always_comb begin
      rdata_o = '0;
      unique case (1'b1)
         hit(addr_i, RA_EVT_STAT): rdata_o = evt_view;
         hit(addr_i, RA_FLT_STAT): rdata_o = flt_stat_q;
         hit(addr_i, RA_EVT_BLK):  rdata_o = evt_blk_q;
         hit(addr_i, RA_FLT_BLK):  rdata_o = flt_blk_q;
         hit(addr_i, RA_EVT_EN):   rdata_o = evt_en_q;
         hit(addr_i, RA_FLT_EN):   rdata_o = flt_en_q;
         hit(addr_i, RA_SRST):     rdata_o[RESET_BIT] = busy;
         hit(addr_i, RA_LIVE):     rdata_o = live_word;
         default:                  rdata_o = '0;
      endcase
   end

   assign irq_o      = (|(evt_stat_q & evt_en_q))
                     | (evt_en_q[SUMMARY_BIT] & |(flt_stat_q & flt_en_q));
   assign soft_rst_o = busy;

   // R9: with every enable clear the line is quiet
   a_r9_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_en_q == '0) |-> !irq_o);
   // R9: the line never rises without a latched bit
   a_r9_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (evt_stat_q != '0 || flt_stat_q != '0));
   // R6: writing the event word never disturbs the fault word
   a_r6_summary_unstored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_evt_stat && flt_i == '0 && !busy) |=> $stable(flt_stat_q));
   // R10: writes during soft reset reach no enable
   a_r10_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> (evt_en_q == '0 && flt_en_q == '0));
endmodule

// File: tb/sdis_irq_status_test.sv
module sdis_irq_status_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] EV  = 16'h0D3F;
   localparam logic [15:0] FV  = 16'h7F7F;
   localparam logic [15:0] ENW = 16'h8D3F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [15:0] rdata;
   logic [15:0] evt = '0;
   logic [15:0] flt = '0;
   logic        h_inh = 0, h_busy = 0, h_tx = 0, h_rx = 0, h_full = 0, h_empty = 0;
   logic        irq, srst;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdis_irq_status uut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
      .rdata_o(rdata), .evt_i(evt), .flt_i(flt),
      .cmd_inhibit_i(h_inh), .card_busy_i(h_busy), .tx_active_i(h_tx),
      .rx_active_i(h_rx), .fifo_full_i(h_full), .fifo_empty_i(h_empty),
      .irq_o(irq), .soft_rst_o(srst));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      addr = a; #1; chk(tag, rdata, exp);
   endtask

   task automatic pulse(input logic [15:0] e, input logic [15:0] f);
      @(negedge clk); evt = e; flt = f;
      @(negedge clk); evt = '0; flt = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: every register zero after reset
      for (int a = 0; a < 7; a++) rd(3'(a), 16'h0, "R12 reset value");
      #1; chk("R12 irq after reset", {15'b0, irq}, 16'h0);

      // R2/R4: single-bit event sweep
      for (int b = 0; b < 16; b++) begin
         pulse(16'h1 << b, '0);
         rd(3'd0, (16'h1 << b) & EV & 16'h7FFF, "R2 event bit latch");
         wr(3'd0, 32'h0000_0000);
         rd(3'd0, (16'h1 << b) & EV & 16'h7FFF, "R4 zero write keeps");
         wr(3'd0, 32'h1 << b);
         rd(3'd0, 16'h0, "R4 event bit clear");
      end

      // R3/R6: single-bit fault sweep
      for (int b = 0; b < 16; b++) begin
         logic [15:0] e;
         e = (16'h1 << b) & FV;
         pulse('0, 16'h1 << b);
         rd(3'd1, e, "R3 fault bit latch");
         rd(3'd0, (e != 0) ? 16'h8000 : 16'h0, "R6 summary reflects fault");
         wr(3'd1, 32'h1 << b);
         rd(3'd1, 16'h0, "R4 fault bit clear");
         rd(3'd0, 16'h0, "R6 summary drops");
      end

      // R4: all-ones clear of both words
      pulse(16'hFFFF, 16'hFFFF);
      rd(3'd0, EV | 16'h8000, "R2 all events");
      wr(3'd1, 32'h0000_FFFF);
      rd(3'd1, 16'h0, "R4 all-ones fault clear");
      wr(3'd0, 32'h0000_FFFF);
      rd(3'd0, 16'h0, "R4 all-ones event clear");

      // R6: writing bit 15 does not clear faults
      pulse('0, 16'h0022);
      wr(3'd0, 32'h0000_8000);
      rd(3'd1, 16'h0022, "R6 summary write ignored");
      rd(3'd0, 16'h8000, "R6 summary still set");
      wr(3'd1, 32'h0000_FFFF);

      // R5: event coincident with clear
      @(negedge clk); addr = 3'd0; wdata = 32'h0000_0003; we = 1'b1; evt = 16'h0003;
      @(negedge clk); we = 1'b0; evt = '0;
      rd(3'd0, 16'h0003, "R5 event wins over clear");
      @(negedge clk); addr = 3'd0; wdata = 32'h0000_0001; we = 1'b1; evt = 16'h0010;
      @(negedge clk); we = 1'b0; evt = '0;
      rd(3'd0, 16'h0012, "R5 clear other bit, new event");
      @(negedge clk); addr = 3'd1; wdata = 32'h0000_0100; we = 1'b1; flt = 16'h0100;
      @(negedge clk); we = 1'b0; flt = '0;
      rd(3'd1, 16'h0100, "R5 fault wins over clear");
      wr(3'd0, 32'hFFFF); wr(3'd1, 32'hFFFF);

      // R1: upper data ignored, write masks
      wr(3'd4, 32'hABCD_FFFF);
      rd(3'd4, ENW, "R1 enable write mask");
      wr(3'd5, 32'h1234_FFFF);
      rd(3'd5, FV, "R1 fault enable mask");
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, EV, "R1 event block mask");
      wr(3'd4, 32'h0); wr(3'd5, 32'h0); wr(3'd2, 32'h0);

      // R7: block sweep
      for (int b = 0; b < 16; b++) begin
         if (EV[b]) begin
            wr(3'd2, 32'h1 << b);
            pulse(16'hFFFF, '0);
            rd(3'd0, EV & ~(16'h1 << b), "R7 blocked event");
            wr(3'd0, 32'hFFFF);
         end
      end
      wr(3'd2, 32'h0);

      // R8: only data timeout can be blocked
      wr(3'd3, 32'h0000_FFFF);
      rd(3'd3, 16'h0010, "R8 fault block readback");
      pulse('0, 16'hFFFF);
      rd(3'd1, FV & ~16'h0010, "R8 data timeout blocked");
      wr(3'd1, 32'hFFFF); wr(3'd3, 32'h0);
      pulse('0, 16'h0010);
      rd(3'd1, 16'h0010, "R8 data timeout latches when unblocked");
      wr(3'd1, 32'hFFFF);

      // R9: enable matching per live event bit
      for (int b = 0; b < 16; b++) begin
         if (EV[b]) begin
            logic [15:0] other;
            other = (b == 0) ? 16'h0002 : 16'h0001;
            wr(3'd4, 32'h1 << b);
            pulse(16'h1 << b, '0);
            #1; chk("R9 enabled bit raises irq", {15'b0, irq}, 16'h1);
            wr(3'd4, {16'h0, other});
            #1; chk("R9 other enable quiet", {15'b0, irq}, 16'h0);
            wr(3'd4, 32'h0);
            #1; chk("R9 zero enable quiet", {15'b0, irq}, 16'h0);
            rd(3'd0, 16'h1 << b, "R9 status kept after disable");
            wr(3'd0, 32'hFFFF);
         end
      end
      // R9: fault path through summary enable
      wr(3'd4, 32'h8000); wr(3'd5, 32'h0010);
      pulse('0, 16'h0010);
      #1; chk("R9 fault enable raises irq", {15'b0, irq}, 16'h1);
      wr(3'd5, 32'h0001);
      #1; chk("R9 unmatched fault enable quiet", {15'b0, irq}, 16'h0);
      wr(3'd5, 32'h0010); wr(3'd4, 32'h0000);
      #1; chk("R9 summary enable gates faults", {15'b0, irq}, 16'h0);
      rd(3'd1, 16'h0010, "R9 fault kept after disable");

      // R10: soft reset sequence
      wr(3'd4, 32'h0001); wr(3'd2, 32'h0002); wr(3'd3, 32'h0010);
      pulse(16'h0001, '0);
      @(negedge clk); addr = 3'd6; wdata = 32'h0000_0100; we = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (c == 0) begin
            addr = 3'd4; wdata = 32'h0000_FFFF; we = 1'b1; evt = 16'h0001;
         end else begin
            we = 1'b0; evt = '0; addr = 3'd6;
         end
         #1;
         if (c != 0) chk("R10 reset bit reads 1", rdata, 16'h0100);
         chk("R10 soft_rst_o high", {15'b0, srst}, 16'h1);
      end
      @(negedge clk); we = 1'b0; evt = '0;
      rd(3'd6, 16'h0, "R10 reset bit self-clears");
      chk("R10 soft_rst_o low", {15'b0, srst}, 16'h0);
      for (int a = 0; a < 6; a++) rd(3'd0 + 3'(a), 16'h0, "R10 registers zeroed");
      #1; chk("R10 irq low after reset", {15'b0, irq}, 16'h0);

      // R11: live status, all 64 patterns
      for (int p = 0; p < 64; p++) begin
         logic [15:0] e;
         @(negedge clk);
         {h_empty, h_full, h_rx, h_tx, h_busy, h_inh} = 6'(p);
         e = '0;
         e[0] = p[0]; e[1] = p[1]; e[8] = p[2]; e[9] = p[3]; e[12] = p[4]; e[13] = p[5];
         rd(3'd7, e, "R11 live status word");
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule